// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block sits between the oscillator and the rest of a small 8-bit processor. It runs every flop from the raw oscillator clock. It derives a divide-by-two enable strobe from that clock, so internal timing does not depend on the oscillator's duty cycle. From that strobe it produces two clock enables: one for the processor core and one for the peripherals and interrupt logic. It also produces a machine-cycle strobe, with one machine cycle equal to six divided periods.

The processor asks for a low-power mode by writing two mode bits: a doze bit and a sleep bit.
- **Doze** stops only the core enable. The peripheral enable keeps running, and any pending interrupt returns the block to run mode.
- **Sleep** drops the oscillator-enable output, which freezes all internal clocking. Only a reset leaves sleep.

A high level on the reset pin turns the oscillator back on. That lets the divider count out the reset qualification even from sleep. The reset pin is accepted only after it has stayed high for two full machine cycles. An accepted reset returns the block to run mode with every enable restored.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: Outside sleep, `periph_ce_o` is high on exactly every second oscillator cycle (a divide-by-two strobe).
- R2: `core_ce_o` equals `periph_ce_o` in run mode and is low in doze and sleep.
- R3: A mode write in run mode with `wr_doze_i`=1 and `wr_sleep_i`=0 enters doze on the next edge (`doze_o`=1), and `periph_ce_o` keeps strobing throughout doze.
- R4: In doze, `irq_pend_i`=1 returns the block to run mode on the next edge, clearing `doze_o`, and `core_ce_o` strobes again at the next divided-clock edge.
- R5: In sleep with the reset pin low, `osc_en_o`, `periph_ce_o` and `core_ce_o` are all low, and `irq_pend_i` has no effect on `sleep_o`.
- R6: A mode write with both `wr_doze_i` and `wr_sleep_i` set enters sleep, not doze.
- R7: `sys_rst_o` rises only after the reset pin has been high for 12 divided periods (two machine cycles). A pulse of 22 oscillator cycles is never accepted, a hold of 30 cycles always is, and `sys_rst_o` falls within two cycles after the pin goes low.
- R8: While the reset pin is high, `osc_en_o` is high even in sleep. An accepted reset clears `doze_o` and `sleep_o`.
- R9: Mode writes are ignored outside run mode and while `sys_rst_o` is high.
- R10: `mcyc_stb_o` coincides with a `periph_ce_o` strobe and occurs on every sixth such strobe.
- R11: After power-on reset, the block is in run mode with `osc_en_o`=1 and `sys_rst_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock, clocks every flop |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | Raw reset pin, active high |
| wr_mode_i | input | 1 | Write strobe of the mode register |
| wr_doze_i | input | 1 | Doze bit of the written value |
| wr_sleep_i | input | 1 | Sleep bit of the written value |
| irq_pend_i | input | 1 | Some interrupt is pending |
| core_ce_o | output | 1 | Clock enable for the processor core |
| periph_ce_o | output | 1 | Clock enable for peripherals and interrupt logic |
| mcyc_stb_o | output | 1 | Last divided period of a machine cycle |
| osc_en_o | output | 1 | Oscillator enable |
| sys_rst_o | output | 1 | Qualified reset to the rest of the chip |
| doze_o | output | 1 | Doze mode bit |
| sleep_o | output | 1 | Sleep mode bit |

## Verification
The hardest state to reach is sleep that is then left through the reset pin. Getting there takes a mode write from run mode, which random writes reach quickly. Leaving it needs the pin held high for two machine cycles while the divider has been frozen at an arbitrary phase. The stimulus therefore mixes random mode writes and interrupts with a directed 30-cycle reset hold whenever the bench's mode model has sat in sleep for a while. It also uses directed 22-cycle pulses that sit just below the acceptance threshold.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_DOZE  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pcm_clk_div.sv
module pcm_clk_div #(
  parameter int unsigned TICKS_PER_MC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_run_i,
  input  logic periph_en_i,
  output logic tick_o,
  output logic mcyc_stb_o
);
  localparam int unsigned PW = (TICKS_PER_MC > 1) ? $clog2(TICKS_PER_MC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MC - 1);

  logic          half_q;
  logic [PW-1:0] phase_q;
  logic          adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        half_q <= 1'b0;
    else if (osc_run_i) half_q <= ~half_q;
  end

  assign tick_o = half_q & osc_run_i;
  assign adv    = tick_o & periph_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  phase_q <= '0;
    else if (adv) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign mcyc_stb_o = adv && (phase_q == LAST);

  assert_tick_alternates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_stb_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcyc_stb_o |-> (tick_o && periph_en_i));
endmodule

// File: rtl/pcm_rst_qual.sv
module pcm_rst_qual #(
  parameter int unsigned TICKS_PER_MC = 6,
  parameter int unsigned RST_MC       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic pin_q_o,
  output logic sys_rst_o
);
  localparam int unsigned NEED = TICKS_PER_MC * RST_MC;
  localparam int unsigned CW   = $clog2(NEED + 1);
  localparam logic [CW-1:0] NEED_C = CW'(NEED);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q_o <= 1'b0;
    else         pin_q_o <= pin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!pin_q_o)                   cnt_q <= '0;
    else if (tick_i && cnt_q != NEED_C)  cnt_q <= cnt_q + 1'b1;
  end

  assign sys_rst_o = (cnt_q == NEED_C);

  assert_rst_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_q_o |=> !sys_rst_o);
  assert_rst_needs_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> (pin_q_o && $past(pin_q_o)));
endmodule

// File: rtl/pcm_mode_fsm.sv
module pcm_mode_fsm
  import pcm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sys_rst_i,
  input  logic     wr_i,
  input  logic     doze_i,
  input  logic     sleep_i,
  input  logic     irq_i,
  output pm_mode_e mode_o
);
  pm_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (sys_rst_i) begin
      mode_d = PM_RUN;
    end else begin
      unique case (mode_q)
        PM_RUN: if (wr_i) begin
          if (sleep_i)     mode_d = PM_SLEEP;
          else if (doze_i) mode_d = PM_DOZE;
        end
        PM_DOZE:  if (irq_i) mode_d = PM_RUN;
        PM_SLEEP: mode_d = PM_SLEEP;
        default:  mode_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PM_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_sleep_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && !sys_rst_i && wr_i && doze_i && sleep_i) |=> (mode_q == PM_SLEEP));
  assert_irq_wakes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_DOZE && irq_i) |=> (mode_q == PM_RUN));
  assert_sleep_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_SLEEP && !sys_rst_i) |=> (mode_q == PM_SLEEP));
  assert_rst_to_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (mode_q == PM_RUN));
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcm_pkg::*;
#(
  parameter int unsigned TICKS_PER_MC = 6,
  parameter int unsigned RST_MC       = 2
) (
  input  logic clk_osc_i,
  input  logic por_ni,
  input  logic rst_pin_i,
  input  logic wr_mode_i,
  input  logic wr_doze_i,
  input  logic wr_sleep_i,
  input  logic irq_pend_i,
  output logic core_ce_o,
  output logic periph_ce_o,
  output logic mcyc_stb_o,
  output logic osc_en_o,
  output logic sys_rst_o,
  output logic doze_o,
  output logic sleep_o
);
  pm_mode_e mode;
  logic     tick, pin_q, osc_run, not_sleep;

  assign not_sleep = (mode != PM_SLEEP);
  assign osc_run   = not_sleep | pin_q;

  pcm_clk_div #(.TICKS_PER_MC(TICKS_PER_MC)) u_div (
    .clk_i(clk_osc_i), .rst_ni(por_ni), .osc_run_i(osc_run),
    .periph_en_i(not_sleep), .tick_o(tick), .mcyc_stb_o(mcyc_stb_o)
  );

  pcm_rst_qual #(.TICKS_PER_MC(TICKS_PER_MC), .RST_MC(RST_MC)) u_rst (
    .clk_i(clk_osc_i), .rst_ni(por_ni), .pin_i(rst_pin_i), .tick_i(tick),
    .pin_q_o(pin_q), .sys_rst_o(sys_rst_o)
  );

  pcm_mode_fsm u_fsm (
    .clk_i(clk_osc_i), .rst_ni(por_ni), .sys_rst_i(sys_rst_o),
    .wr_i(wr_mode_i), .doze_i(wr_doze_i), .sleep_i(wr_sleep_i),
    .irq_i(irq_pend_i), .mode_o(mode)
  );

  assign periph_ce_o = tick & not_sleep;
  assign core_ce_o   = tick & (mode == PM_RUN);
  assign osc_en_o    = osc_run;
  assign doze_o      = (mode == PM_DOZE);
  assign sleep_o     = (mode == PM_SLEEP);

  assert_periph_runs_in_doze_R3: assert property (@(posedge clk_osc_i) disable iff (!por_ni)
    (doze_o && $past(doze_o) && !$past(periph_ce_o)) |-> periph_ce_o);
  assert_sleep_quiet_R5: assert property (@(posedge clk_osc_i) disable iff (!por_ni)
    (sleep_o && !pin_q) |-> (!osc_en_o && !periph_ce_o && !core_ce_o));
  assert_core_subset_R2: assert property (@(posedge clk_osc_i) disable iff (!por_ni)
    core_ce_o |-> periph_ce_o);
endmodule

// File: tb/tb_pwr_clk_ctrl.sv
module tb_pwr_clk_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, rst_pin, wr, wdz, wsl, irq;
  logic core_ce, periph_ce, mcyc_stb, osc_en, sys_rst, doze, sleep;

  pwr_clk_ctrl dut (
    .clk_osc_i(clk), .por_ni(por_n), .rst_pin_i(rst_pin), .wr_mode_i(wr),
    .wr_doze_i(wdz), .wr_sleep_i(wsl), .irq_pend_i(irq),
    .core_ce_o(core_ce), .periph_ce_o(periph_ce), .mcyc_stb_o(mcyc_stb),
    .osc_en_o(osc_en), .sys_rst_o(sys_rst), .doze_o(doze), .sleep_o(sleep)
  );

  int  n_cmp = 0, n_bad = 0;
  int  m_mode = 0;
  int  prev_mode = 0;
  bit  prev_valid = 0, prev_pce = 0, prev_pin = 0, stb_seen = 0, done = 0;
  int  ce_gap = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_mode(input int cur, input bit rst, input bit w,
                                   input bit d, input bit s, input bit i);
    if (rst) return 0;
    if (cur == 0 && w) return s ? 2 : (d ? 1 : 0);
    if (cur == 1 && i) return 0;
    return cur;
  endfunction

  // one oscillator cycle: drive at a falling edge, check at the next one
  task automatic cyc(input bit w, input bit d, input bit s, input bit i, input bit pin);
    int nxt;
    wr = w; wdz = d; wsl = s; irq = i; rst_pin = pin;
    nxt = next_mode(m_mode, sys_rst, w, d, s, i);
    @(negedge clk);
    prev_mode = m_mode;
    m_mode = nxt;
    chk(doze == (m_mode == 1), "R3/R4/R9 doze bit", doze, m_mode == 1);
    chk(sleep == (m_mode == 2), "R6/R9 sleep bit", sleep, m_mode == 2);
    chk(core_ce == (periph_ce && m_mode == 0), "R2 core enable", core_ce, periph_ce && m_mode == 0);
    if (m_mode == 2 && !pin && !prev_pin)
      chk(!osc_en && !periph_ce, "R5 sleep quiet", {osc_en, periph_ce}, 0);
    if (pin) chk(osc_en, "R8 pin wakes oscillator", osc_en, 1);
    if (prev_valid && m_mode != 2 && prev_mode != 2)
      chk(periph_ce != prev_pce, "R1 divide by two", periph_ce, !prev_pce);
    if (mcyc_stb) chk(periph_ce, "R10 strobe on tick", periph_ce, 1);
    if (periph_ce) ce_gap++;
    if (mcyc_stb) begin
      if (stb_seen) chk(ce_gap == 6, "R10 six ticks", ce_gap, 6);
      ce_gap = 0;
      stb_seen = 1;
    end
    prev_pce = periph_ce;
    prev_valid = 1;
    prev_pin = pin;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit seen_rst, seen_core;
    int pce_cnt, sleep_len;
    void'($urandom(32'd4242));
    por_n = 0; rst_pin = 0; wr = 0; wdz = 0; wsl = 0; irq = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk(!doze && !sleep && osc_en && !sys_rst, "R11 power-on state",
        {doze, sleep, osc_en, sys_rst}, 2);

    // short pulse below threshold
    seen_rst = 0;
    for (int k = 0; k < 22; k++) begin cyc(0,0,0,0,1); seen_rst |= sys_rst; end
    for (int k = 0; k < 4; k++)  begin cyc(0,0,0,0,0); seen_rst |= sys_rst; end
    chk(!seen_rst, "R7 short pulse rejected", seen_rst, 0);

    // long hold accepted, write during reset ignored
    for (int k = 0; k < 30; k++) cyc(0,0,0,0,1);
    chk(sys_rst, "R7 long hold accepted", sys_rst, 1);
    cyc(1,1,0,0,1);
    chk(!doze, "R9 write ignored in reset", doze, 0);
    cyc(0,0,0,0,0); cyc(0,0,0,0,0);
    chk(!sys_rst, "R7 reset released", sys_rst, 0);

    // doze: peripherals keep running
    cyc(1,1,0,0,0);
    chk(doze, "R3 doze entered", doze, 1);
    pce_cnt = 0;
    for (int k = 0; k < 20; k++) begin cyc(0,0,0,0,0); pce_cnt += periph_ce; end
    chk(pce_cnt == 10, "R3 periph strobes in doze", pce_cnt, 10);
    cyc(1,0,1,0,0);
    chk(doze && !sleep, "R9 write ignored in doze", sleep, 0);

    // interrupt wakes
    cyc(0,0,0,1,0);
    chk(!doze, "R4 irq clears doze", doze, 0);
    seen_core = core_ce;
    cyc(0,0,0,0,0); seen_core |= core_ce;
    chk(seen_core, "R4 core restarts", seen_core, 1);

    // both bits: sleep wins; irq ignored
    cyc(1,1,1,0,0);
    chk(sleep && !doze, "R6 sleep priority", {sleep, doze}, 2);
    for (int k = 0; k < 6; k++) cyc(0,0,0,1,0);
    chk(sleep && !osc_en, "R5 irq ignored in sleep", {sleep, osc_en}, 2);

    // reset out of sleep
    for (int k = 0; k < 30; k++) cyc(0,0,0,0,1);
    chk(sys_rst, "R8 reset accepted from sleep", sys_rst, 1);
    cyc(0,0,0,0,0); cyc(0,0,0,0,0);
    chk(!sleep && !doze && osc_en, "R8 reset clears modes", {sleep, doze, osc_en}, 1);

    // random phase
    sleep_len = 0;
    for (int k = 0; k < 6000; k++) begin
      if (m_mode == 2) sleep_len++; else sleep_len = 0;
      if (sleep_len > 12) begin
        for (int j = 0; j < 30; j++) cyc(0,0,0,0,1);
        sleep_len = 0;
      end else begin
        bit w = ($urandom % 8) == 0;
        bit d = $urandom % 2;
        bit s = ($urandom % 4) == 0;
        bit i = ($urandom % 16) == 0;
        cyc(w, d, s, i, 0);
      end
    end
    finish_run();
  end
endmodule